// File: doc/BRIEF.md
# Switching Transient Capture Unit

This block records a short burst of ADC samples around every switching edge of one power transistor. Three sample streams arrive in parallel at the ADC rate: collector-emitter voltage, gate-emitter voltage and gate current. The gate PWM command is watched for edges. A rising command edge starts a turn-on record and a falling edge starts a turn-off record. The next `WIN` valid samples of all three channels go into an on-chip buffer. `WIN` lies between 100 and 256, which covers a 2 to 4 µs transient at typical converter rates.

While the window fills, the block tracks the extremes and the start and end averages of the collector-emitter channel. A scan of the buffer then finds the 10 % and 90 % crossings. When the scan is done, a one-cycle `record_valid` pulse presents the edge tag, the overshoot and the transition time. The record then streams out on a valid/ready port. The buffer stays frozen until the last beat is accepted. PWM edges that arrive in that time are dropped and raise a sticky overrun flag.

The sample input has no ready. The ADC cannot be stalled, so a sample offered while no capture is open is lost. The readout port obeys normal back-pressure: once `out_valid` is high, it and the beat stay fixed until `out_ready` takes the beat, and the consumer may hold `out_ready` low for as long as it likes.

Top module: `sw_transient_capture`

## Requirements
- R1: An edge is a change of `pwm_in` between consecutive clocks. An edge seen while idle opens a capture. The record's `rec_turn_on` is 1 for a low-to-high edge and 0 for a high-to-low edge.
- R2: A capture stores the first `WIN` cycles with `samp_valid` high, counting from the clock after the edge. A sample offered in the edge cycle itself, or while the unit is not capturing, is not stored.
- R3: An edge seen while capturing, scanning or reading out starts nothing. It sets `overrun`, which stays high until reset.
- R4: `record_valid` is high for exactly one cycle, `WIN` cycles after the cycle that stores the last sample. `out_valid` rises in that same cycle.
- R5: Readout gives `WIN` beats in capture order, each carrying the three channels of one sample. `out_last` marks beat `WIN`-1. While `out_valid` is high and `out_ready` is low, the beat does not change.
- R6: The buffer is frozen from the end of a capture until the last beat is accepted. Only after that can an edge start a new capture.
- R7: Let B be the floor mean of the first 8 collector-emitter samples and S the floor mean of the last 8. If S ≥ B (a rising record), `overshoot` is max−S when the window maximum exceeds S, and 0 otherwise.
- R8: Let D = S−B. The thresholds are T10 = B + D/10 and T90 = B + 9·D/10, with division truncating toward zero. `edge_time` is the index of the first sample at or beyond T90 minus the index of the first sample at or beyond T10. "Beyond" means ≥ for a rising record and ≤ for a falling one.
- R9: If S < B (a falling record), `overshoot` is S−min when the window minimum lies below S, and 0 otherwise.
- R10: After reset, `record_valid`, `out_valid`, `overrun`, `overshoot` and `edge_time` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; sample strobe and readout share it |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 1 | Gate PWM command |
| samp_valid | input | 1 | ADC sample strobe, no ready |
| vce_in | input | SW | Collector-emitter sample, unsigned |
| vge_in | input | SW | Gate-emitter sample, unsigned |
| ig_in | input | SW | Gate current sample, unsigned |
| record_valid | output | 1 | One-cycle pulse: record and attributes ready |
| rec_turn_on | output | 1 | 1 = turn-on record, 0 = turn-off |
| overrun | output | 1 | Sticky: an edge was dropped |
| overshoot | output | SW | Overshoot beyond the settled level |
| edge_time | output | $clog2(WIN) | 10 %–90 % transition time in samples |
| out_valid | output | 1 | Readout beat valid |
| out_ready | input | 1 | Readout beat accepted |
| out_vce | output | SW | Beat: collector-emitter sample |
| out_vge | output | SW | Beat: gate-emitter sample |
| out_ig | output | SW | Beat: gate current sample |
| out_last | output | 1 | Final beat of the record |

## Verification
The bench builds the block with `WIN` = 100, the smallest legal window. This keeps each record near 300 cycles, so several records fit in one run. The start and end averaging windows lie far apart inside that window. With records this short, the bench can cover gapped sample strobes, a stalling consumer, edges dropped during capture and during readout, and both falling and rising waveforms under either edge tag, so that direction is shown to follow the data and not the tag.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_SCAN = 2'd2,
    ST_SEND = 2'd3
  } trc_state_e;

  // number of samples averaged at each end of the window, as a power of two
  localparam int AVG_LG = 3;
  localparam int AVG    = 1 << AVG_LG;
endpackage

// File: rtl/trc_buffer.sv
module trc_buffer #(
  parameter int DW    = 36,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // simple dual port: one write port fed by the sample strobe, one registered read port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  // R2: writes never leave the window
  a_r2_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(waddr) < DEPTH));
  // R6: a write and a read of the same word never collide
  a_r6_no_rw_clash: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (raddr != waddr) || (waddr == '0));
endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
#(
  parameter int WIN = 128,
  localparam int AW = $clog2(WIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm_in,
  input  logic          samp_valid,
  input  logic          out_ready,
  output logic          cap_start,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          scan_en,
  output logic [AW-1:0] scan_idx,
  output logic          scan_last,
  output logic          turn_on,
  output logic          record_valid,
  output logic          overrun,
  output logic          out_valid,
  output logic          out_last
);
  localparam logic [AW-1:0] LAST = AW'(WIN - 1);

  trc_state_e    st;
  logic          pwm_q;
  logic          edge_seen;
  logic [AW-1:0] cnt;
  logic [AW-1:0] rptr;
  logic [AW-1:0] rnext;
  logic          fire;

  assign edge_seen = pwm_in ^ pwm_q;
  assign fire      = out_valid && out_ready;
  assign cap_start = (st == ST_IDLE) && edge_seen;
  assign wr_en     = (st == ST_CAPT) && samp_valid;
  assign wr_addr   = cnt;
  assign scan_en   = (st == ST_SCAN);
  assign scan_idx  = rptr;
  assign scan_last = scan_en && (rptr == LAST);
  assign out_valid = (st == ST_SEND);
  assign out_last  = out_valid && (rptr == LAST);

  // read pointer: the buffer's registered output always shows word rptr
  always_comb begin
    unique case (st)
      ST_SCAN: rnext = (rptr == LAST) ? '0 : rptr + 1'b1;
      ST_SEND: rnext = fire ? rptr + 1'b1 : rptr;
      default: rnext = '0;
    endcase
  end
  assign rd_addr = rnext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      pwm_q        <= 1'b0;
      cnt          <= '0;
      rptr         <= '0;
      turn_on      <= 1'b0;
      record_valid <= 1'b0;
      overrun      <= 1'b0;
    end else begin
      pwm_q        <= pwm_in;
      rptr         <= rnext;
      record_valid <= 1'b0;
      if (edge_seen && st != ST_IDLE) overrun <= 1'b1;
      unique case (st)
        ST_IDLE: if (edge_seen) begin
          st      <= ST_CAPT;
          turn_on <= pwm_in;
          cnt     <= '0;
        end
        ST_CAPT: if (samp_valid) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= ST_SCAN;
        end
        ST_SCAN: if (rptr == LAST) begin
          st           <= ST_SEND;
          record_valid <= 1'b1;
        end
        ST_SEND: if (fire && rptr == LAST) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: the record strobe is a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    record_valid |=> !record_valid);
  // R4: readout opens in the strobe cycle
  a_r4_opens_readout: assert property (@(posedge clk) disable iff (!rst_n)
    record_valid |-> out_valid);
  // R3: overrun never clears outside reset
  a_r3_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R5: a stalled beat stays offered
  a_r5_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  // R6: no capture opens while a record is being read out
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> !wr_en);
endmodule

// File: rtl/trc_attr.sv
module trc_attr
  import trc_pkg::*;
#(
  parameter int SW  = 12,
  parameter int WIN = 128,
  localparam int IW = $clog2(WIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_start,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [SW-1:0] wr_vce,
  input  logic          scan_en,
  input  logic [IW-1:0] scan_idx,
  input  logic [SW-1:0] scan_vce,
  input  logic          scan_last,
  output logic [SW-1:0] overshoot,
  output logic [IW-1:0] edge_time
);
  localparam int SUMW = SW + AVG_LG;
  localparam int XW   = SW + 6;
  localparam logic [IW-1:0] LO_END = IW'(AVG);
  localparam logic [IW-1:0] HI_BEG = IW'(WIN - AVG);
  localparam logic signed [XW-1:0] TEN  = XW'(10);
  localparam logic signed [XW-1:0] NINE = XW'(9);

  logic [SW-1:0]   vmax, vmin;
  logic [SUMW-1:0] sum_b, sum_s;
  logic [SW-1:0]   b_mean, s_mean;
  logic signed [XW-1:0] b_w, s_w, d_w, t10, t90, val_w;
  logic            rising, hit10, hit90;
  logic            f10, f90;
  logic [IW-1:0]   i10, i90;

  // running extremes and end sums, gathered while samples are written
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vmax  <= '0;
      vmin  <= '0;
      sum_b <= '0;
      sum_s <= '0;
    end else if (cap_start) begin
      vmax  <= '0;
      vmin  <= '1;
      sum_b <= '0;
      sum_s <= '0;
    end else if (wr_en) begin
      if (wr_vce > vmax) vmax <= wr_vce;
      if (wr_vce < vmin) vmin <= wr_vce;
      if (wr_idx < LO_END)  sum_b <= sum_b + SUMW'(wr_vce);
      if (wr_idx >= HI_BEG) sum_s <= sum_s + SUMW'(wr_vce);
    end
  end

  assign b_mean = SW'(sum_b >> AVG_LG);
  assign s_mean = SW'(sum_s >> AVG_LG);
  assign b_w    = signed'(XW'(b_mean));
  assign s_w    = signed'(XW'(s_mean));
  assign d_w    = s_w - b_w;
  assign rising = (d_w >= 0);
  assign t10    = b_w + d_w / TEN;
  assign t90    = b_w + (d_w * NINE) / TEN;
  assign val_w  = signed'(XW'(scan_vce));
  assign hit10  = rising ? (val_w >= t10) : (val_w <= t10);
  assign hit90  = rising ? (val_w >= t90) : (val_w <= t90);

  // crossing search over the frozen buffer, first hit wins
  always_ff @(posedge clk) begin
    if (!rst_n || cap_start) begin
      f10 <= 1'b0;
      f90 <= 1'b0;
      i10 <= '0;
      i90 <= '0;
    end else if (scan_en) begin
      if (!f10 && hit10) begin
        f10 <= 1'b1;
        i10 <= scan_idx;
      end
      if (!f90 && hit90) begin
        f90 <= 1'b1;
        i90 <= scan_idx;
      end
    end
  end

  always_comb begin
    if (rising) overshoot = (vmax > s_mean) ? vmax - s_mean : '0;
    else        overshoot = (vmin < s_mean) ? s_mean - vmin : '0;
  end
  assign edge_time = i90 - i10;

  // R8: both crossings exist once the scan has covered the window
  a_r8_crossings_found: assert property (@(posedge clk) disable iff (!rst_n)
    scan_last |=> (f10 && f90));
  // R8: the far threshold is never met before the near one
  a_r8_order: assert property (@(posedge clk) disable iff (!rst_n)
    f90 |-> (f10 && i10 <= i90));
endmodule

// File: rtl/sw_transient_capture.sv
module sw_transient_capture #(
  parameter int SW  = 12,
  parameter int WIN = 128,
  localparam int IW = $clog2(WIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm_in,
  input  logic          samp_valid,
  input  logic [SW-1:0] vce_in,
  input  logic [SW-1:0] vge_in,
  input  logic [SW-1:0] ig_in,
  output logic          record_valid,
  output logic          rec_turn_on,
  output logic          overrun,
  output logic [SW-1:0] overshoot,
  output logic [IW-1:0] edge_time,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_vce,
  output logic [SW-1:0] out_vge,
  output logic [SW-1:0] out_ig,
  output logic          out_last
);
  localparam int DW = 3 * SW;

  logic          cap_start, wr_en, scan_en, scan_last;
  logic [IW-1:0] wr_addr, rd_addr, scan_idx;
  logic [DW-1:0] rdata;

  trc_ctrl #(.WIN(WIN)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwm_in       (pwm_in),
    .samp_valid   (samp_valid),
    .out_ready    (out_ready),
    .cap_start    (cap_start),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .rd_addr      (rd_addr),
    .scan_en      (scan_en),
    .scan_idx     (scan_idx),
    .scan_last    (scan_last),
    .turn_on      (rec_turn_on),
    .record_valid (record_valid),
    .overrun      (overrun),
    .out_valid    (out_valid),
    .out_last     (out_last)
  );

  trc_buffer #(.DW(DW), .DEPTH(WIN)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata ({ig_in, vge_in, vce_in}),
    .raddr (rd_addr),
    .rdata (rdata)
  );

  trc_attr #(.SW(SW), .WIN(WIN)) u_attr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_start (cap_start),
    .wr_en     (wr_en),
    .wr_idx    (wr_addr),
    .wr_vce    (vce_in),
    .scan_en   (scan_en),
    .scan_idx  (scan_idx),
    .scan_vce  (rdata[SW-1:0]),
    .scan_last (scan_last),
    .overshoot (overshoot),
    .edge_time (edge_time)
  );

  assign out_vce = rdata[SW-1:0];
  assign out_vge = rdata[2*SW-1:SW];
  assign out_ig  = rdata[3*SW-1:2*SW];

  // R5: a stalled beat keeps its payload
  a_r5_beat_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_vce) && $stable(out_vge) && $stable(out_ig)));
  // R7: attributes hold while the record is read out
  a_r7_attr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> ($stable(overshoot) && $stable(edge_time)));
endmodule

// File: tb/sim_sw_transient_capture.sv
module sim_sw_transient_capture;
  localparam int SW  = 12;
  localparam int WIN = 100;
  localparam int IW  = $clog2(WIN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_in = 1'b0;
  logic samp_valid = 1'b0;
  logic [SW-1:0] vce_in = '0, vge_in = '0, ig_in = '0;
  logic out_ready = 1'b0;
  logic record_valid, rec_turn_on, overrun, out_valid, out_last;
  logic [SW-1:0] overshoot, out_vce, out_vge, out_ig;
  logic [IW-1:0] edge_time;

  always #5 clk = ~clk;

  sw_transient_capture #(.SW(SW), .WIN(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .samp_valid(samp_valid),
    .vce_in(vce_in), .vge_in(vge_in), .ig_in(ig_in),
    .record_valid(record_valid), .rec_turn_on(rec_turn_on), .overrun(overrun),
    .overshoot(overshoot), .edge_time(edge_time),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_vce(out_vce), .out_vge(out_vge), .out_ig(out_ig), .out_last(out_last));

  int n_chk = 0, n_bad = 0, cyc = 0;
  int kind = 0, smode = 0, rmode = 0, gen_i = 0;
  logic pwm_seen = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int wave(input int k, input int i);
    if (k == 0) begin
      if (i < 12) return 60 + (i % 4);
      if (i < 32) return 60 + (i - 12) * 140;
      if (i < 38) return 3300 - (i - 32) * 40;
      return 3000 + (i % 5);
    end else if (k == 1) begin
      if (i < 12) return 2950 + (i % 4);
      if (i < 32) return 2950 - (i - 12) * 140;
      if (i < 38) return 30 + (i - 32) * 10;
      return 120 + (i % 3);
    end
    return 1500;
  endfunction

  // stimulus driver: away from the edges, posedge + 2
  always @(posedge clk) begin
    #2;
    cyc++;
    if (pwm_in != pwm_seen) begin
      gen_i = 0;
      pwm_seen = pwm_in;
    end
    samp_valid = rst_n && ((smode == 0) || (cyc % 3 != 0));
    if (samp_valid) begin
      vce_in = SW'(wave(kind, gen_i));
      vge_in = SW'((gen_i * 29 + kind * 100) % 4096);
      ig_in  = SW'((gen_i * 53 + 7) % 4096);
      gen_i++;
    end
    out_ready = (rmode == 0) || ((cyc % 4 != 1) && (cyc % 7 != 3));
  end

  // behavioural reference model
  int m_st = 0, m_cnt = 0, m_k = 0;
  bit m_rv = 0, m_ovr = 0, m_tag = 0, m_pwm = 0;
  int q_vce[$], q_vge[$], q_ig[$];
  int e_os = 0, e_et = 0;

  function automatic void expect_attr();
    int b = 0, s = 0, d, t10, t90, i10 = -1, i90 = -1, mx = 0, mn = 4095;
    bit up;
    for (int i = 0; i < 8; i++) begin
      b += q_vce[i];
      s += q_vce[WIN - 8 + i];
    end
    b /= 8; s /= 8; d = s - b; up = (d >= 0);
    t10 = b + d / 10;
    t90 = b + (d * 9) / 10;
    for (int i = 0; i < WIN; i++) begin
      if (q_vce[i] > mx) mx = q_vce[i];
      if (q_vce[i] < mn) mn = q_vce[i];
      if (i10 < 0 && (up ? q_vce[i] >= t10 : q_vce[i] <= t10)) i10 = i;
      if (i90 < 0 && (up ? q_vce[i] >= t90 : q_vce[i] <= t90)) i90 = i;
    end
    e_et = i90 - i10;
    if (up) e_os = (mx > s) ? mx - s : 0;
    else    e_os = (mn < s) ? s - mn : 0;
  endfunction

  always @(posedge clk) begin
    bit edg;
    if (!rst_n) begin
      m_st = 0; m_rv = 0; m_ovr = 0; m_pwm = 0;
    end else begin
      edg = (pwm_in != m_pwm);
      m_pwm = pwm_in;
      m_rv = 0;
      if (edg && m_st != 0) m_ovr = 1;
      case (m_st)
        0: if (edg) begin
          m_st = 1; m_tag = pwm_in;
          q_vce.delete(); q_vge.delete(); q_ig.delete();
        end
        1: if (samp_valid) begin
          q_vce.push_back(int'(vce_in)); q_vge.push_back(int'(vge_in)); q_ig.push_back(int'(ig_in));
          if (q_vce.size() == WIN) begin
            m_st = 2; m_cnt = 0; expect_attr();
          end
        end
        2: begin
          m_cnt++;
          if (m_cnt == WIN) begin
            m_st = 3; m_rv = 1; m_k = 0;
          end
        end
        default: if (out_ready) begin
          m_k++;
          if (m_k == WIN) m_st = 0;
        end
      endcase
    end
  end

  // comparison on every clock, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(record_valid == m_rv, "R4", record_valid, m_rv);
      check(out_valid == (m_st == 3), "R6", out_valid, m_st == 3);
      check(overrun == m_ovr, "R3", overrun, m_ovr);
      if (m_st == 3 && out_valid) begin
        check(out_vce == SW'(q_vce[m_k]), "R2", out_vce, q_vce[m_k]);
        check(out_vge == SW'(q_vge[m_k]) && out_ig == SW'(q_ig[m_k]), "R5", {out_ig, out_vge},
              {SW'(q_ig[m_k]), SW'(q_vge[m_k])});
        check(out_last == (m_k == WIN - 1), "R5", out_last, m_k == WIN - 1);
      end
      if (m_rv) begin
        check(rec_turn_on == m_tag, "R1", rec_turn_on, m_tag);
        check(int'(overshoot) == e_os, (q_vce[WIN-1] >= q_vce[0]) ? "R7" : "R9", overshoot, e_os);
        check(int'(edge_time) == e_et, "R8", edge_time, e_et);
      end
    end
  end

  task automatic run_record(input bit lvl, input int k, input int sm, input int rm,
                            input int flip_at);
    @(negedge clk);
    kind = k; smode = sm; rmode = rm;
    pwm_in = lvl;
    wait (m_st != 0);
    if (flip_at > 0) begin
      repeat (flip_at) @(negedge clk);
      pwm_in = ~pwm_in;
    end
    wait (m_st == 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state
    check(record_valid == 0, "R10", record_valid, 0);
    check(out_valid == 0, "R10", out_valid, 0);
    check(overrun == 0, "R10", overrun, 0);
    check(overshoot == 0 && edge_time == 0, "R10", overshoot + edge_time, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_record(1'b1, 1, 0, 0, 0);   // turn-on, falling voltage, no stalls
    run_record(1'b0, 0, 1, 1, 0);   // turn-off, rising voltage, gaps and stalls
    run_record(1'b1, 0, 0, 1, 0);   // rising voltage under a turn-on tag
    run_record(1'b0, 2, 1, 0, 0);   // flat record
    check(overrun == 0, "R3", overrun, 0);
    run_record(1'b1, 1, 1, 1, 40);  // edge dropped mid-capture
    check(overrun == 1, "R3", overrun, 1);
    run_record(1'b1, 0, 0, 1, 150); // edge dropped during scan or readout
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule